// File: doc/BRIEF.md
# Reset and Boot Sequencer

This block gathers every reason the processor may need to restart into one active-low CPU reset and then walks through a fixed start-up order. The reasons are a low supply (power-on or brownout, with the supply monitor given as a digital level), a watchdog expiry pulse, a software restart pulse, and a low level on a shared bidirectional reset pin. After a supply event the block holds reset until the supply is good. It then waits a programmable oscillator settle time, asserts reset for a minimum width, and releases the processor.

On release the block first publishes the boot-code entry address 8000h. One cycle later it decides from three loader controls whether to stay in boot code or to publish the application entry 0000h. Sticky cause flags record why the last reset happened. When the reset came from inside the chip, the block pulls the shared pin low for as long as the processor is held. It ignores its own echo on that pin.

Top module: `reset_boot_seq`

## Requirements
- R1: While rst_ni is low, cpu_reset_no, rst_pin_oe_o, start_pc_valid_o and all cause_o bits are 0.
- R2: A low supply_ok_i in any state holds cpu_reset_no low and rst_pin_oe_o high from the next cycle until the supply returns.
- R3: From the clock edge that first sees the supply good (after power-on or brownout), cpu_reset_no stays low for exactly TSU_CYCLES + PULSE_CYCLES cycles.
- R4: At the end of the oscillator wait, cause_o[0] (power flag) is set and cause_o[1] (watchdog) and cause_o[2] (external) are cleared.
- R5: A wdt_rst_i pulse while the CPU runs gives a reset of PULSE_CYCLES cycles and sets cause_o[1].
- R6: A sw_rst_i pulse while the CPU runs gives a reset of PULSE_CYCLES cycles and changes no cause flag.
- R7: rst_pin_i low for H cycles while the CPU runs, seen through a two-flop synchronizer, gives a reset of max(H, PULSE_CYCLES) cycles and sets cause_o[2].
- R8: rst_pin_oe_o is high in exactly the reset cycles caused by brownout, watchdog or software reset, and never for a plain power-on or external reset.
- R9: rst_pin_i is ignored while rst_pin_oe_o is high and for two cycles after it falls, so an internal reset never sets cause_o[2].
- R10: In the first cycle after release, start_pc_valid_o is high with start_pc_o = 16'h8000.
- R11: In the next cycle, if (i2c_ldr_en_i | jtag_ldr_en_i) & ~pwd_lock_i holds, no further strobe follows; otherwise start_pc_valid_o is high with start_pc_o = 16'h0000.
- R12: Cause flags hold until flag_clr_i bit n is high, which clears bit n. A flag being set in the same cycle wins over its clear.
- R13: wdt_rst_i and sw_rst_i are ignored while the CPU is held in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| supply_ok_i | input | 1 | Supply above brownout level |
| wdt_rst_i | input | 1 | Watchdog expiry pulse |
| sw_rst_i | input | 1 | Software restart pulse |
| rst_pin_i | input | 1 | Level read back from the shared reset pin, active low |
| i2c_ldr_en_i | input | 1 | Serial-bus loader enabled |
| jtag_ldr_en_i | input | 1 | Debug-port loader enabled |
| pwd_lock_i | input | 1 | Loader locked by password |
| flag_clr_i | input | 3 | Per-bit clear of cause flags |
| cpu_reset_no | output | 1 | CPU reset, active low |
| start_pc_o | output | 16 | Entry address |
| start_pc_valid_o | output | 1 | Entry address strobe |
| rst_pin_oe_o | output | 1 | Drive the reset pin low |
| cause_o | output | 3 | Cause flags {external, watchdog, power} |

## Verification
All eight loader-control combinations are applied behind a software reset. Each one tells apart a boot-code stay from an application jump. External pin pulses of one to eight cycles are swept, and these separate the minimum-width path from the pin-held path. Brownouts of one to three cycles show that the hold time adds to the settle time, not overlapping it. Watchdog and software resets check the pin echo, and they check that the block's own low drive never comes back as an external cause.

// File: rtl/reset_boot_pkg.sv
`timescale 1ns/1ps
package reset_boot_pkg;
  typedef enum logic [2:0] {
    ST_POR_HOLD   = 3'd0,
    ST_BO_HOLD    = 3'd1,
    ST_OSC_WAIT   = 3'd2,
    ST_RST_ASSERT = 3'd3,
    ST_BOOT_CHECK = 3'd4,
    ST_RUN        = 3'd5
  } seq_state_e;

  localparam logic [15:0] BOOT_VEC = 16'h8000;
  localparam logic [15:0] USER_VEC = 16'h0000;
  localparam int CAUSE_W = 3;
  localparam int C_POR   = 0;
  localparam int C_WDT   = 1;
  localparam int C_EXT   = 2;
endpackage

// File: rtl/reset_boot_sync.sv
`timescale 1ns/1ps
module reset_boot_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/reset_boot_timer.sv
`timescale 1ns/1ps
module reset_boot_timer #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/reset_boot_select.sv
`timescale 1ns/1ps
module reset_boot_select (
  input  logic i2c_en_i,
  input  logic jtag_en_i,
  input  logic lock_i,
  output logic jump_user_o
);
  // loader only runs when some loader is enabled and not locked
  assign jump_user_o = ~((i2c_en_i | jtag_en_i) & ~lock_i);
endmodule

// File: rtl/reset_boot_seq.sv
`timescale 1ns/1ps
module reset_boot_seq
  import reset_boot_pkg::*;
#(
  parameter int TSU_CYCLES   = 50000,
  parameter int PULSE_CYCLES = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               supply_ok_i,
  input  logic               wdt_rst_i,
  input  logic               sw_rst_i,
  input  logic               rst_pin_i,
  input  logic               i2c_ldr_en_i,
  input  logic               jtag_ldr_en_i,
  input  logic               pwd_lock_i,
  input  logic [CAUSE_W-1:0] flag_clr_i,
  output logic               cpu_reset_no,
  output logic [15:0]        start_pc_o,
  output logic               start_pc_valid_o,
  output logic               rst_pin_oe_o,
  output logic [CAUSE_W-1:0] cause_o
);
  localparam int MAXC = (TSU_CYCLES > PULSE_CYCLES) ? TSU_CYCLES : PULSE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] TSU_LD   = CW'(TSU_CYCLES - 1);
  localparam logic [CW-1:0] PULSE_LD = CW'(PULSE_CYCLES - 1);

  seq_state_e st_q, st_d;
  logic bc_ph_q;
  logic int_src_q, int_src_d;
  logic [SYNC_STAGES-1:0] oe_d_q;
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic pin_sync_n, ext_req, oe, in_reset_hold, running;
  logic tmr_load, tmr_done, jump_user;
  logic [CW-1:0] tmr_val;
  logic set_por, set_wdt, set_ext;

  reset_boot_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rst_pin_i), .q_o(pin_sync_n)
  );

  reset_boot_timer #(.CW(CW)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load),
    .load_val_i(tmr_val), .done_o(tmr_done)
  );

  reset_boot_select u_select (
    .i2c_en_i(i2c_ldr_en_i), .jtag_en_i(jtag_ldr_en_i),
    .lock_i(pwd_lock_i), .jump_user_o(jump_user)
  );

  assign in_reset_hold = (st_q == ST_BO_HOLD) || (st_q == ST_OSC_WAIT) ||
                         (st_q == ST_RST_ASSERT);
  assign running       = (st_q == ST_BOOT_CHECK) || (st_q == ST_RUN);
  assign oe            = int_src_q & in_reset_hold;
  // own drive echoes through the synchronizer: mask it for the pipeline depth
  assign ext_req       = ~pin_sync_n & ~oe & ~(|oe_d_q);

  always_comb begin
    st_d      = st_q;
    int_src_d = int_src_q;
    tmr_load  = 1'b0;
    tmr_val   = PULSE_LD;
    set_por   = 1'b0;
    set_wdt   = 1'b0;
    set_ext   = 1'b0;
    if (!supply_ok_i) begin
      st_d      = ST_BO_HOLD;
      int_src_d = 1'b1;
    end else begin
      unique case (st_q)
        ST_POR_HOLD, ST_BO_HOLD: begin
          st_d     = ST_OSC_WAIT;
          tmr_load = 1'b1;
          tmr_val  = TSU_LD;
        end
        ST_OSC_WAIT: if (tmr_done) begin
          st_d     = ST_RST_ASSERT;
          tmr_load = 1'b1;
          set_por  = 1'b1;
        end
        ST_RST_ASSERT: if (tmr_done && !ext_req) begin
          st_d      = ST_BOOT_CHECK;
          int_src_d = 1'b0;
        end
        ST_BOOT_CHECK, ST_RUN: begin
          if (wdt_rst_i) begin
            st_d = ST_RST_ASSERT; tmr_load = 1'b1; int_src_d = 1'b1; set_wdt = 1'b1;
          end else if (sw_rst_i) begin
            st_d = ST_RST_ASSERT; tmr_load = 1'b1; int_src_d = 1'b1;
          end else if (ext_req) begin
            st_d = ST_RST_ASSERT; tmr_load = 1'b1; int_src_d = 1'b0; set_ext = 1'b1;
          end else if (st_q == ST_BOOT_CHECK && bc_ph_q) begin
            st_d = ST_RUN;
          end
        end
        default: st_d = ST_POR_HOLD;
      endcase
    end
  end

  always_comb begin
    if (set_por) begin
      cause_d        = '0;
      cause_d[C_POR] = 1'b1;
    end else begin
      cause_d[C_POR] = flag_clr_i[C_POR] ? 1'b0 : cause_q[C_POR];
      cause_d[C_WDT] = set_wdt ? 1'b1 : (flag_clr_i[C_WDT] ? 1'b0 : cause_q[C_WDT]);
      cause_d[C_EXT] = set_ext ? 1'b1 : (flag_clr_i[C_EXT] ? 1'b0 : cause_q[C_EXT]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_POR_HOLD;
      bc_ph_q   <= 1'b0;
      int_src_q <= 1'b0;
      oe_d_q    <= '0;
      cause_q   <= '0;
    end else begin
      st_q      <= st_d;
      bc_ph_q   <= (st_q == ST_BOOT_CHECK) && (st_d == ST_BOOT_CHECK);
      int_src_q <= int_src_d;
      oe_d_q    <= {oe_d_q[SYNC_STAGES-2:0], oe};
      cause_q   <= cause_d;
    end
  end

  assign cpu_reset_no     = running;
  assign rst_pin_oe_o     = oe;
  assign cause_o          = cause_q;
  assign start_pc_o       = bc_ph_q ? USER_VEC : BOOT_VEC;
  assign start_pc_valid_o = (st_q == ST_BOOT_CHECK) && (!bc_ph_q || jump_user);
endmodule

// File: rtl/reset_boot_seq_chk.sv
`timescale 1ns/1ps
module reset_boot_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        supply_ok_i,
  input logic        wdt_rst_i,
  input logic [2:0]  flag_clr_i,
  input logic        cpu_reset_no,
  input logic [15:0] start_pc_o,
  input logic        start_pc_valid_o,
  input logic        rst_pin_oe_o,
  input logic [2:0]  cause_o
);
  p_bo_holds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (!cpu_reset_no && rst_pin_oe_o));

  p_wdt_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_reset_no && supply_ok_i && wdt_rst_i) |=> cause_o[1]);

  p_oe_only_in_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pin_oe_o |-> !cpu_reset_no);

  p_boot_vector_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_reset_no) |-> (start_pc_valid_o && start_pc_o == 16'h8000));

  p_user_after_boot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_pc_valid_o && start_pc_o == 16'h0000) |->
      ($past(start_pc_valid_o) && $past(start_pc_o) == 16'h8000));

  p_flag_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o[1] && !flag_clr_i[1] && cpu_reset_no) |=> cause_o[1]);
endmodule

bind reset_boot_seq reset_boot_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .supply_ok_i(supply_ok_i),
  .wdt_rst_i(wdt_rst_i), .flag_clr_i(flag_clr_i),
  .cpu_reset_no(cpu_reset_no), .start_pc_o(start_pc_o),
  .start_pc_valid_o(start_pc_valid_o), .rst_pin_oe_o(rst_pin_oe_o),
  .cause_o(cause_o)
);

// File: tb/reset_boot_seq_bench.sv
`timescale 1ns/1ps
module reset_boot_seq_bench;
  localparam int TSU = 8;
  localparam int PUL = 4;
  localparam int WIN = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b1, wdt = 1'b0, sw = 1'b0, ext_drv_n = 1'b1;
  logic i2c_en = 1'b0, jtag_en = 1'b0, lock = 1'b0;
  logic [2:0] flag_clr = 3'b000;
  logic cpu_reset_n, pc_valid, pin_oe, pin;
  logic [15:0] pc;
  logic [2:0] cause;

  int n_vec = 0, n_err = 0;
  int lo_cnt, oe_cnt, bv_cnt, uv_cnt;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  assign pin = pin_oe ? 1'b0 : ext_drv_n;

  reset_boot_seq #(.TSU_CYCLES(TSU), .PULSE_CYCLES(PUL)) u_reset_boot_seq (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(supply_ok), .wdt_rst_i(wdt),
    .sw_rst_i(sw), .rst_pin_i(pin), .i2c_ldr_en_i(i2c_en),
    .jtag_ldr_en_i(jtag_en), .pwd_lock_i(lock), .flag_clr_i(flag_clr),
    .cpu_reset_no(cpu_reset_n), .start_pc_o(pc), .start_pc_valid_o(pc_valid),
    .rst_pin_oe_o(pin_oe), .cause_o(cause)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic observe(input int n);
    lo_cnt = 0; oe_cnt = 0; bv_cnt = 0; uv_cnt = 0;
    repeat (n) begin
      @(negedge clk);
      if (!cpu_reset_n) lo_cnt++;
      if (pin_oe) oe_cnt++;
      if (pc_valid && pc == 16'h8000) bv_cnt++;
      if (pc_valid && pc == 16'h0000) uv_cnt++;
    end
  endtask

  task automatic pulse_wdt();
    wdt = 1'b1; @(negedge clk); wdt = 1'b0;
  endtask

  task automatic pulse_sw();
    sw = 1'b1; @(negedge clk); sw = 1'b0;
  endtask

  task automatic clear_flags();
    flag_clr = 3'b111; @(negedge clk); flag_clr = 3'b000;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: held in power-on reset
    chk("R1 cpu_reset", int'(cpu_reset_n), 0);
    chk("R1 pin_oe", int'(pin_oe), 0);
    chk("R1 cause", int'(cause), 0);
    chk("R1 valid", int'(pc_valid), 0);

    // power-on release
    fork
      rst_n = 1'b1;
      observe(WIN);
    join
    chk("R3 por reset length", lo_cnt, TSU + PUL);
    chk("R8 no pin drive on power-on", oe_cnt, 0);
    chk("R10 boot strobe", bv_cnt, 1);
    chk("R11 user strobe, loaders off", uv_cnt, 1);
    chk("R4 power flag", int'(cause), 3'b001);

    // watchdog
    fork
      pulse_wdt();
      observe(WIN);
    join
    chk("R5 wdt reset length", lo_cnt, PUL);
    chk("R8 wdt pin drive", oe_cnt, PUL);
    chk("R5 wdt flag, power kept", int'(cause), 3'b011);
    chk("R9 own drive not external", int'(cause[2]), 0);

    // R12 clear and set-wins
    flag_clr = 3'b001; @(negedge clk); flag_clr = 3'b000;
    chk("R12 clear power flag", int'(cause), 3'b010);
    fork
      begin wdt = 1'b1; flag_clr = 3'b010; @(negedge clk); wdt = 1'b0; flag_clr = 3'b000; end
      observe(WIN);
    join
    chk("R12 set wins over clear", int'(cause), 3'b010);
    clear_flags();
    chk("R12 clear all", int'(cause), 0);

    // software reset across all loader control patterns
    for (int c = 0; c < 8; c++) begin
      i2c_en = c[0]; jtag_en = c[1]; lock = c[2];
      fork
        pulse_sw();
        observe(WIN);
      join
      chk("R6 sw reset length", lo_cnt, PUL);
      chk("R8 sw pin drive", oe_cnt, PUL);
      chk("R10 boot strobe", bv_cnt, 1);
      chk("R11 user strobe", uv_cnt, ((c[0] || c[1]) && !c[2]) ? 0 : 1);
      chk("R6 R9 flags untouched", int'(cause), 0);
    end
    i2c_en = 1'b0; jtag_en = 1'b0; lock = 1'b0;

    // R13: watchdog during a held reset is ignored
    fork
      begin pulse_sw(); @(negedge clk); pulse_wdt(); end
      observe(WIN);
    join
    chk("R13 reset length unchanged", lo_cnt, PUL);
    chk("R13 wdt flag not set", int'(cause[1]), 0);

    // external pin sweep
    for (int h = 1; h <= 8; h++) begin
      fork
        begin ext_drv_n = 1'b0; repeat (h) @(negedge clk); ext_drv_n = 1'b1; end
        observe(WIN);
      join
      chk("R7 ext reset length", lo_cnt, (h > PUL) ? h : PUL);
      chk("R8 no pin drive on ext", oe_cnt, 0);
      chk("R7 ext flag", int'(cause), 3'b100);
      clear_flags();
    end

    // brownout sweep
    for (int d = 1; d <= 3; d++) begin
      fork
        pulse_wdt();
        observe(WIN);
      join
      fork
        begin supply_ok = 1'b0; repeat (d) @(negedge clk); supply_ok = 1'b1; end
        observe(WIN);
      join
      chk("R2 R3 brownout reset length", lo_cnt, d + TSU + PUL);
      chk("R8 brownout pin drive", oe_cnt, d + TSU + PUL);
      chk("R4 power flag clears wdt", int'(cause), 3'b001);
      chk("R10 boot strobe after brownout", bv_cnt, 1);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_vec++;
      n_err++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule